// File: doc/BRIEF.md
# Legacy Screen Window Remapper

This block watches a CPU write bus and folds writes aimed at two legacy 32 KB screen windows into a larger high-resolution frame buffer whose line pitch is fixed at 256 bytes. Each legacy window is organised as 256 lines of 128 bytes. The lower window (byte addresses 0x20000 to 0x27FFF) lands in the left half of the top 256 frame-buffer lines. The upper window (0x28000 to 0x2FFFF) lands in the right half of the same lines. Writes addressed straight at the frame buffer (0x4C0000 upward) pass through with their address unchanged. Only the lower 240 KB of that 256 KB region is backed by memory, so direct writes into the top 16 KB are dropped.

Legacy writes are filtered by the current display setting. This stops old software that pokes the legacy windows from corrupting a picture drawn in the newer colour modes or resolutions. An external inhibit input can also block the lower window. Reads are not handled here, because an external shadow RAM answers them. The block registers one frame-buffer write per accepted bus write, one clock later.

Internally a small path register records which route the last bus cycle took. Its states are `PATH_IDLE`, `PATH_LOW`, `PATH_HIGH` and `PATH_DIRECT`. From any state, an accepted write to the lower window goes to `PATH_LOW`, to the upper window goes to `PATH_HIGH`, and to live frame-buffer memory goes to `PATH_DIRECT`. Every other cycle, including a rejected or out-of-range write, goes to `PATH_IDLE`. The frame-buffer write enable is high in every state except `PATH_IDLE`.

Top module: `srm_legacy_remap`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `fb_we` is 0 and `fb_addr`, `fb_be` and `fb_data` are all zero.
- R2: With `mode_sel` 00 (4-colour) or 01 (8-colour), `hres_sel` 00 and `aspect_sel` 0, a write to 0x20000+o produces a frame-buffer write at 0x4C0000 + o[14:7]*256 + o[6:0].
- R3: When allowed, a write to 0x28000+o produces a frame-buffer write at 0x4C0000 + o[14:7]*256 + 128 + o[6:0].
- R4: A write to the upper window is dropped (no `fb_we`) unless `mode_sel` is 00 or 01 and both `hres_sel` is 00 and `aspect_sel` is 0.
- R5: A write to the lower window is dropped when `mode_sel` is 10 (16-colour) or 11 (256-colour).
- R6: With `mode_sel` 00 or 01 and any other `hres_sel` or `aspect_sel` value, lower-window writes are still remapped as in R2.
- R7: When `scr0_inhibit` is 1, lower-window writes are dropped. The inhibit has no effect on upper-window or direct writes.
- R8: A write to 0x4C0000 through 0x4FBFFF is passed through at the same address. A write to 0x4FC000 through 0x4FFFFF is dropped.
- R9: On every frame-buffer write, `fb_data` equals the bus data and `fb_be` equals the bus byte strobes (bit 1 upper byte, bit 0 lower byte) of the originating write.
- R10: Writes to any other address, and cycles with `bus_wr` low, produce no frame-buffer write.
- R11: Each accepted write gives `fb_we` high for exactly the one cycle after the bus write is sampled. `fb_we` returns low on the next cycle unless another accepted write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 24 | Bus byte address |
| bus_be | input | 2 | Byte-lane strobes of the write |
| bus_data | input | 16 | Write data |
| mode_sel | input | 2 | Colour mode: 00 4-colour, 01 8-colour, 10 16-colour, 11 256-colour |
| hres_sel | input | 2 | Horizontal resolution code, 00 is the base 512 setting |
| aspect_sel | input | 1 | 0 for 2:1 pixels, 1 for square pixels |
| scr0_inhibit | input | 1 | External block of lower-window writes |
| fb_we | output | 1 | Frame-buffer write enable |
| fb_addr | output | 24 | Frame-buffer byte address |
| fb_be | output | 2 | Frame-buffer byte-lane strobes |
| fb_data | output | 16 | Frame-buffer write data |

## Verification
Every result of a bus write is due one clock after the edge that samples it. This covers the enable, the remapped address, the strobes and the data. The bench drives inputs just after a falling edge and samples the outputs at the next falling edge. At that point exactly one rising edge has passed, so the value seen must belong to the previous cycle's stimulus. A behavioural model queues the expected write for that following sample. It compares the enable on every cycle, and the address, strobes and data whenever a write is expected. Dropped writes and idle cycles are checked by requiring the enable to be low in that same following sample.

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [1:0] {
        PATH_IDLE   = 2'b00,
        PATH_LOW    = 2'b01,
        PATH_HIGH   = 2'b10,
        PATH_DIRECT = 2'b11
    } path_e;

    typedef enum logic [1:0] {
        CM_FOUR  = 2'b00,
        CM_EIGHT = 2'b01,
        CM_SIXTN = 2'b10,
        CM_BYTE  = 2'b11
    } colour_e;

    localparam int unsigned NUM_WIN = 2;

endpackage

// File: rtl/srm_region_decode.sv
module srm_region_decode #(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned WIN_BASE  = 32'h0002_0000,
    parameter int unsigned WIN_BYTES = 32768,
    parameter int unsigned FB_BASE   = 32'h004C_0000,
    parameter int unsigned FB_LIVE   = 245760,
    parameter int unsigned FB_BYTES  = 262144,
    localparam int unsigned WIN_OFS_W = $clog2(WIN_BYTES),
    localparam int unsigned FB_OFS_W  = $clog2(FB_BYTES)
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [1:0]           hit_win,
    output logic [WIN_OFS_W-1:0] win_ofs,
    output logic                 hit_fb,
    output logic [FB_OFS_W-1:0]  fb_ofs
);

    localparam logic [ADDR_W-1:0] FB_LO = ADDR_W'(FB_BASE);
    localparam logic [ADDR_W-1:0] FB_HI = ADDR_W'(FB_BASE + FB_LIVE);

    for (genvar g = 0; g < 2; g++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_BASE + g * WIN_BYTES);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_BASE + (g + 1) * WIN_BYTES);
        assign hit_win[g] = (addr >= LO) && (addr < HI);
    end

    // Windows and frame buffer are size-aligned, so offsets are low address bits.
    assign win_ofs = addr[WIN_OFS_W-1:0];
    assign hit_fb  = (addr >= FB_LO) && (addr < FB_HI);
    assign fb_ofs  = addr[FB_OFS_W-1:0];

endmodule

// File: rtl/srm_mode_policy.sv
module srm_mode_policy
    import srm_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic [1:0] hres_sel,
    input  logic       aspect_sel,
    input  logic       scr0_inhibit,
    output logic [1:0] allow_win
);

    colour_e cm;
    logic    legacy_depth;
    logic    base_res;

    assign cm = colour_e'(mode_sel);

    always_comb begin
        unique case (cm)
            CM_FOUR, CM_EIGHT: legacy_depth = 1'b1;
            CM_SIXTN, CM_BYTE: legacy_depth = 1'b0;
            default:           legacy_depth = 1'b0;
        endcase
    end

    // Base setting: narrowest horizontal code with 2:1 pixels.
    assign base_res = (hres_sel == 2'b00) && !aspect_sel;

    assign allow_win[0] = legacy_depth && !scr0_inhibit;
    assign allow_win[1] = legacy_depth && base_res;

endmodule

// File: rtl/srm_win_map.sv
module srm_win_map #(
    parameter int unsigned WIN_IDX    = 0,
    parameter int unsigned WIN_OFS_W  = 15,
    parameter int unsigned LINE_BYTES = 128,
    parameter int unsigned PITCH      = 256,
    parameter int unsigned FB_OFS_W   = 18,
    localparam int unsigned COL_W     = $clog2(LINE_BYTES),
    localparam int unsigned PITCH_W   = $clog2(PITCH)
) (
    input  logic [WIN_OFS_W-1:0] win_ofs,
    output logic [FB_OFS_W-1:0]  fb_ofs
);

    logic [FB_OFS_W-1:0] row_part;
    logic [FB_OFS_W-1:0] lane_part;
    logic [FB_OFS_W-1:0] col_part;

    assign row_part  = FB_OFS_W'(win_ofs[WIN_OFS_W-1:COL_W]) << PITCH_W;
    assign lane_part = FB_OFS_W'(WIN_IDX * LINE_BYTES);
    assign col_part  = FB_OFS_W'(win_ofs[COL_W-1:0]);
    assign fb_ofs    = row_part | lane_part | col_part;

endmodule

// File: rtl/srm_legacy_remap.sv
module srm_legacy_remap
    import srm_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned WIN_BASE   = 32'h0002_0000,
    parameter int unsigned WIN_BYTES  = 32768,
    parameter int unsigned LINE_BYTES = 128,
    parameter int unsigned PITCH      = 256,
    parameter int unsigned FB_BASE    = 32'h004C_0000,
    parameter int unsigned FB_BYTES   = 262144,
    parameter int unsigned FB_LIVE    = 245760,
    localparam int unsigned BE_W      = DATA_W / 8,
    localparam int unsigned WIN_OFS_W = $clog2(WIN_BYTES),
    localparam int unsigned FB_OFS_W  = $clog2(FB_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        hres_sel,
    input  logic              aspect_sel,
    input  logic              scr0_inhibit,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [BE_W-1:0]   fb_be,
    output logic [DATA_W-1:0] fb_data
);

    localparam logic [ADDR_W-1:0] FB_END = ADDR_W'(FB_BASE + FB_LIVE);
    localparam logic [ADDR_W-FB_OFS_W-1:0] FB_TOP = FB_BASE[ADDR_W-1:FB_OFS_W];

    logic [1:0]           hit_win;
    logic [1:0]           allow_win;
    logic                 hit_fb;
    logic [WIN_OFS_W-1:0] win_ofs;
    logic [FB_OFS_W-1:0]  direct_ofs;
    logic [FB_OFS_W-1:0]  mapped_ofs [NUM_WIN];

    path_e               path_q, path_d;
    logic [FB_OFS_W-1:0] ofs_d, ofs_q;
    logic [BE_W-1:0]     be_q;
    logic [DATA_W-1:0]   data_q;

    srm_region_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
        .FB_BASE(FB_BASE), .FB_LIVE(FB_LIVE), .FB_BYTES(FB_BYTES)
    ) u_decode (
        .addr(bus_addr), .hit_win(hit_win), .win_ofs(win_ofs),
        .hit_fb(hit_fb), .fb_ofs(direct_ofs)
    );

    srm_mode_policy u_policy (
        .mode_sel(mode_sel), .hres_sel(hres_sel), .aspect_sel(aspect_sel),
        .scr0_inhibit(scr0_inhibit), .allow_win(allow_win)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_map
        srm_win_map #(
            .WIN_IDX(w), .WIN_OFS_W(WIN_OFS_W), .LINE_BYTES(LINE_BYTES),
            .PITCH(PITCH), .FB_OFS_W(FB_OFS_W)
        ) u_map (
            .win_ofs(win_ofs), .fb_ofs(mapped_ofs[w])
        );
    end

    // Next path selection
    always_comb begin
        path_d = PATH_IDLE;
        ofs_d  = ofs_q;
        if (bus_wr) begin
            unique case ({hit_fb, hit_win})
                3'b001: if (allow_win[0]) begin path_d = PATH_LOW;    ofs_d = mapped_ofs[0]; end
                3'b010: if (allow_win[1]) begin path_d = PATH_HIGH;   ofs_d = mapped_ofs[1]; end
                3'b100: begin                   path_d = PATH_DIRECT; ofs_d = direct_ofs;    end
                default: path_d = PATH_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) path_q <= PATH_IDLE;
        else        path_q <= path_d;
    end

    // Write payload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            be_q   <= '0;
            data_q <= '0;
        end else if (path_d != PATH_IDLE) begin
            ofs_q  <= ofs_d;
            be_q   <= bus_be;
            data_q <= bus_data;
        end
    end

    // Outputs
    always_comb begin
        unique case (path_q)
            PATH_IDLE:                         fb_we = 1'b0;
            PATH_LOW, PATH_HIGH, PATH_DIRECT:  fb_we = 1'b1;
            default:                           fb_we = 1'b0;
        endcase
        fb_addr = (ofs_q == '0 && be_q == '0 && data_q == '0 && path_q == PATH_IDLE)
                  ? '0 : {FB_TOP, ofs_q};
        fb_be   = be_q;
        fb_data = data_q;
    end

    AST_REGION_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_fb, hit_win}));                                             // R10
    AST_WE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> $past(bus_wr));                                                 // R10
    AST_PAYLOAD_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (fb_data == $past(bus_data)) && (fb_be == $past(bus_be)));      // R9
    AST_HIGH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_win[1] && !allow_win[1]) |=> !fb_we);                      // R4
    AST_LOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_win[0] && !allow_win[0]) |=> !fb_we);                      // R5
    AST_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (fb_addr < FB_END));                                            // R8
    AST_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_win[1] && allow_win[1]) |=> fb_we && fb_addr[$clog2(LINE_BYTES)]); // R3

endmodule

// File: tb/srm_legacy_remap_tb_top.sv
module srm_legacy_remap_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_data = '0;
    logic [1:0]  mode_sel = '0;
    logic [1:0]  hres_sel = '0;
    logic        aspect_sel = 1'b0;
    logic        scr0_inhibit = 1'b0;
    logic        fb_we;
    logic [23:0] fb_addr;
    logic [1:0]  fb_be;
    logic [15:0] fb_data;

    int checks = 0;
    int fails  = 0;

    // expected result for the next sample
    logic        exp_we = 1'b0;
    int          exp_addr = 0;
    logic [1:0]  exp_be = '0;
    logic [15:0] exp_data = '0;
    string       exp_tag = "R1";

    always #5 clk = ~clk;

    srm_legacy_remap dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_data(bus_data), .mode_sel(mode_sel),
        .hres_sel(hres_sel), .aspect_sel(aspect_sel), .scr0_inhibit(scr0_inhibit),
        .fb_we(fb_we), .fb_addr(fb_addr), .fb_be(fb_be), .fb_data(fb_data)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural model of one bus cycle
    task automatic model(input logic wr, input int a);
        int o;
        exp_we = 1'b0;
        if (!wr) begin
            exp_tag = "R11";
            return;
        end
        if (a >= 'h20000 && a < 'h28000) begin
            o = a - 'h20000;
            exp_addr = 'h4C0000 + (o / 128) * 256 + (o % 128);
            exp_we = (mode_sel < 2) && !scr0_inhibit;
            if (mode_sel >= 2)                        exp_tag = "R5";
            else if (scr0_inhibit)                    exp_tag = "R7";
            else if (hres_sel != 0 || aspect_sel)     exp_tag = "R6";
            else                                      exp_tag = "R2";
        end else if (a >= 'h28000 && a < 'h30000) begin
            o = a - 'h28000;
            exp_addr = 'h4C0000 + (o / 128) * 256 + 128 + (o % 128);
            exp_we = (mode_sel < 2) && hres_sel == 0 && !aspect_sel;
            exp_tag = exp_we ? "R3" : "R4";
        end else if (a >= 'h4C0000 && a < 'h500000) begin
            exp_addr = a;
            exp_we = (a < 'h4FC000);
            exp_tag = "R8";
        end else begin
            exp_tag = "R10";
        end
        exp_be = bus_be;
        exp_data = bus_data;
    endtask

    // one cycle: sample the previous result, then apply new stimulus
    task automatic step(input logic wr, input int a, input logic [1:0] m, input logic [1:0] h,
                        input logic ar, input logic inh);
        @(negedge clk);
        check(exp_tag, int'(fb_we), int'(exp_we), "fb_we");
        if (exp_we) begin
            check(exp_tag, int'(fb_addr), exp_addr, "fb_addr");
            check("R9", int'(fb_data), int'(exp_data), "fb_data");
            check("R9", int'(fb_be), int'(exp_be), "fb_be");
        end
        bus_wr = wr; bus_addr = a[23:0];
        bus_be = 2'($urandom_range(1, 3)); bus_data = 16'($urandom);
        mode_sel = m; hres_sel = h; aspect_sel = ar; scr0_inhibit = inh;
        model(wr, a);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(fb_we), 0, "fb_we in reset");
        check("R1", int'(fb_addr), 0, "fb_addr in reset");
        check("R1", int'(fb_data), 0, "fb_data in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(fb_we), 0, "fb_we after reset");
        check("R1", int'(fb_be), 0, "fb_be after reset");
        exp_we = 1'b0; exp_tag = "R11";

        // R2 corners: first and last byte of the lower window
        step(1, 'h20000, 0, 0, 0, 0);
        step(1, 'h27FFF, 1, 0, 0, 0);
        step(1, 'h200FF, 0, 0, 0, 0);
        // R3 corners
        step(1, 'h28000, 0, 0, 0, 0);
        step(1, 'h2FFFF, 1, 0, 0, 0);
        step(1, 'h2807F, 0, 0, 0, 0);
        // R4: upper window blocked at higher settings
        step(1, 'h28010, 0, 1, 0, 0);
        step(1, 'h28010, 0, 0, 1, 0);
        step(1, 'h28010, 2, 0, 0, 0);
        step(1, 'h28010, 3, 0, 0, 0);
        // R5: lower window blocked in 16 and 256 colour modes
        step(1, 'h20010, 2, 0, 0, 0);
        step(1, 'h20010, 3, 3, 1, 0);
        // R6: lower window still mapped at higher resolution
        step(1, 'h21234, 0, 3, 1, 0);
        step(1, 'h21234, 1, 2, 0, 0);
        // R7: inhibit blocks lower only
        step(1, 'h20020, 0, 0, 0, 1);
        step(1, 'h28020, 0, 0, 0, 1);
        step(1, 'h4C0020, 2, 0, 0, 1);
        // R8: direct pass-through and dead top region
        step(1, 'h4C0000, 3, 3, 1, 0);
        step(1, 'h4FBFFF, 3, 3, 1, 0);
        step(1, 'h4FC000, 3, 3, 1, 0);
        step(1, 'h4FFFFF, 0, 0, 0, 0);
        // R10: other addresses
        step(1, 'h1FFFF, 0, 0, 0, 0);
        step(1, 'h30000, 0, 0, 0, 0);
        step(1, 'h4BFFFF, 0, 0, 0, 0);
        // R11: single pulse then idle
        step(1, 'h20002, 0, 0, 0, 0);
        step(0, 'h20002, 0, 0, 0, 0);
        step(0, 'h20002, 0, 0, 0, 0);

        // random mix across all regions and settings
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 5);
            int a;
            case (sel)
                0: a = 'h20000 + $urandom_range(0, 'h7FFF);
                1: a = 'h28000 + $urandom_range(0, 'h7FFF);
                2: a = 'h4C0000 + $urandom_range(0, 'h3FFFF);
                3: a = $urandom_range(0, 'h1FFFF);
                4: a = 'h20000 + $urandom_range(0, 'hFFFF);
                default: a = $urandom_range(0, 'hFFFFFF);
            endcase
            step(1'($urandom_range(0, 3) != 0), a, 2'($urandom), 2'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0));
        end
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule